// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Timer

This block provides two independent down-counting timers side by side. Timer 0 is a general-purpose timer and timer 1 is a real-time-clock timer. Each timer chains a prescaler into a main counter. The prescaler counts down on every enabled clock. Each time it passes through zero it reloads from its own preset and hands one tick to the counter. When the counter is ticked from one down to zero, the timer raises a one-cycle expiry pulse on its own output. The counter then either restarts from its preset or stays parked at zero, depending on that timer's mode.

Software reaches the block through a simple word-addressed register bus. The write side is a single-cycle write strobe; the read side is combinational and follows the address. Each timer has a counter preset and a prescaler preset that can be written and read back. The live counter and prescaler values can be read. Both timers are steered through one shared control word, which cannot be read back. That word holds a 4-bit field per timer: two persistent mode bits (reload-at-zero and count-enable) and two self-clearing command bits (load-counter and load-prescaler). Since every write to the control word sets the mode bits of both timers, software has to restate the other timer's mode bits on each write.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After a synchronous active-low reset, both timers are disabled and in stop mode. All presets, prescaler values and counter values read as zero, and neither expiry output is high.
- R2: While a timer is enabled, its prescaler decrements by one per clock. On a clock where the prescaler is zero, it reloads its preset and gives one tick to the counter, so ticks arrive every preset+1 clocks. A prescaler preset of 0 therefore ticks on every clock.
- R3: Each tick lowers a non-zero counter by one. The tick that takes the counter from 1 to 0 makes the expiry output of that timer high for exactly the following cycle.
- R4: Control bit 0 of a field selects the action at expiry. With bit 0 at 1, the counter takes its preset at the expiry edge and keeps counting. With bit 0 at 0, the counter stays at zero and gives no further expiry pulses until it is loaded again.
- R5: Writing 1 to control bit 1 of a field loads that counter from its preset at the write edge. Writing 0 does nothing. If a load and a tick fall on the same edge, the load wins and no expiry pulse is produced.
- R6: Writing 1 to control bit 3 of a field loads that prescaler from its preset at the write edge and suppresses that clock's tick. Writing 0 does nothing.
- R7: Control bit 2 of a field enables counting. While it is 0, the prescaler and the counter of that timer both hold their values.
- R8: In the control word, the timer 0 field occupies bits 3:0 and the timer 1 field occupies bits 11:8. One write sets the mode bits of both timers at the same time.
- R9: Word addresses are fixed as follows. Address 0 is the timer 0 counter preset and address 1 is the timer 0 prescaler preset. Address 2 is the timer 1 counter preset and address 3 is the timer 1 prescaler preset. Address 4 is the control word, which reads as zero. Address 5 is the timer 0 counter value and address 6 is the timer 0 prescaler value. Address 7 is the timer 1 counter value and address 8 is the timer 1 prescaler value. Any other address reads as zero.
- R10: The two timers run independently. Each has its own expiry output, and the activity of one never changes the values or pulses of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W (4) | Word address for both read and write |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Combinational read data for `addr` |
| gp_expire | output | 1 | One-cycle expiry pulse of timer 0 |
| rt_expire | output | 1 | One-cycle expiry pulse of timer 1 |

## Verification
The bench repeats a counter-load command at a sweep of offsets, so that a load eventually lands on the same edge as the tick from 1 to 0. A design that let the tick win there would emit a stray expiry pulse or leave the counter at zero or at preset minus one. It also exercises a prescaler preset of zero together with a counter preset of one, where the expiry must fire on every clock. A design with an off-by-one in the prescaler period would drop pulses in that case. Control writes that change one timer's field are checked to leave the other timer running when its mode bits are restated. Writes of zero to the command bits must leave both datapaths untouched. A design that latched the command bits, or decoded the wrong field position, would reload or stall the neighbouring timer.

// File: rtl/dpt_pkg.sv
// dpt_pkg: shared constants, register addresses and control-field layout
// for the dual prescaled timer. Assumes exactly two timers, whose control
// fields sit at a stride of eight bits inside the shared control word.
package dpt_pkg;

    localparam int NUM_TIMERS   = 2;
    localparam int FIELD_STRIDE = 8;
    localparam int FIELD_W      = 4;
    localparam int ADDR_CTRL    = 4;

    // One timer's control field. Packed order puts reload at bit 0 and
    // load-prescaler at bit 3.
    typedef struct packed {
        logic ld_scl;
        logic enable;
        logic ld_cnt;
        logic reload;
    } tmr_field_t;

    function automatic int cnt_preset_addr(input int t);
        return 2 * t;
    endfunction

    function automatic int scl_preset_addr(input int t);
        return 2 * t + 1;
    endfunction

    function automatic int cnt_value_addr(input int t);
        return ADDR_CTRL + 1 + 2 * t;
    endfunction

    function automatic int scl_value_addr(input int t);
        return ADDR_CTRL + 2 + 2 * t;
    endfunction

endpackage

// File: rtl/dpt_regs.sv
// dpt_regs: preset registers plus decoding of the shared control word.
// Holds the persistent reload/enable bits of each timer and turns the
// command bits into single-cycle load strobes. Assumes the write is a
// one-cycle strobe and that the control word is never read back.
module dpt_regs
    import dpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int SCL_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_preset,
    output logic [NUM_TIMERS-1:0][SCL_W-1:0]  scl_preset,
    output logic [NUM_TIMERS-1:0]             reload_mode,
    output logic [NUM_TIMERS-1:0]             count_en,
    output logic [NUM_TIMERS-1:0]             ld_cnt,
    output logic [NUM_TIMERS-1:0]             ld_scl
);

    logic ctrl_wr;
    logic unused_wdata;

    assign ctrl_wr      = wr_en && (addr == ADDR_W'(ADDR_CTRL));
    assign unused_wdata = ^wdata;

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        localparam int BASE = i * FIELD_STRIDE;
        tmr_field_t field;

        assign field = tmr_field_t'(wdata[BASE +: FIELD_W]);

        // Command strobes are only live during the control write itself.
        assign ld_cnt[i] = ctrl_wr && field.ld_cnt;
        assign ld_scl[i] = ctrl_wr && field.ld_scl;

        // Counter preset register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_preset[i] <= '0;
            else if (wr_en && addr == ADDR_W'(cnt_preset_addr(i)))
                cnt_preset[i] <= wdata[CNT_W-1:0];
        end

        // Prescaler preset register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                scl_preset[i] <= '0;
            else if (wr_en && addr == ADDR_W'(scl_preset_addr(i)))
                scl_preset[i] <= wdata[SCL_W-1:0];
        end

        // Persistent mode bits, rewritten by every control write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                reload_mode[i] <= 1'b0;
                count_en[i]    <= 1'b0;
            end else if (ctrl_wr) begin
                reload_mode[i] <= field.reload;
                count_en[i]    <= field.enable;
            end
        end

        // R8
        mode_from_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(ADDR_CTRL)) |=>
                (count_en[i] == $past(wdata[BASE + 2]) &&
                 reload_mode[i] == $past(wdata[BASE])));
    end

endmodule

// File: rtl/dpt_scaler.sv
// dpt_scaler: prescaler for one timer. Counts down while enabled and, on a
// clock where it sits at zero, reloads its preset and emits a tick. A load
// command wins over the countdown and suppresses that clock's tick.
module dpt_scaler #(
    parameter int SCL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [SCL_W-1:0] preset,
    output logic [SCL_W-1:0] value,
    output logic             tick
);

    logic [SCL_W-1:0] scl_q;
    logic             at_zero;

    assign at_zero = (scl_q == '0);
    assign tick    = en && !load && at_zero;
    assign value   = scl_q;

    // Prescaler state: load, then enabled countdown with reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            scl_q <= '0;
        else if (load)
            scl_q <= preset;
        else if (en)
            scl_q <= at_zero ? preset : scl_q - SCL_W'(1);
    end

    // R7
    scl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(scl_q));

    // R6
    scl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (scl_q == $past(preset)));

endmodule

// File: rtl/dpt_counter.sv
// dpt_counter: main down-counter of one timer. Decrements on each tick
// while non-zero. The tick from 1 to 0 registers an expiry pulse and then
// reloads or parks at zero according to the mode. A load command beats a
// simultaneous tick and cancels its expiry.
module dpt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic             reload_mode,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] value,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;
    logic             at_one;
    logic             live;

    assign at_one = (cnt_q == CNT_W'(1));
    assign live   = (cnt_q != '0);
    assign value  = cnt_q;
    assign expire = expire_q;

    // Counter state: load first, otherwise step on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= preset;
        else if (tick && live)
            cnt_q <= at_one ? (reload_mode ? preset : '0) : cnt_q - CNT_W'(1);
    end

    // Expiry pulse register, high for the cycle after the 1-to-0 tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            expire_q <= 1'b0;
        else
            expire_q <= tick && !load && at_one;
    end

    // R3
    expire_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire_q |-> ($past(cnt_q) == CNT_W'(1)));

    // R4
    park_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !reload_mode && cnt_q == '0) |=> (cnt_q == '0 && !expire_q));

    // R5
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(preset) && !expire_q));

endmodule

// File: rtl/dual_prescaled_timer.sv
// dual_prescaled_timer: top level. Two prescaler/counter pairs share one
// write-only control word and a word-addressed register bus. The read
// data is combinational from the address. Assumes a single clock domain.
module dual_prescaled_timer
    import dpt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16,
    parameter int SCL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              gp_expire,
    output logic              rt_expire
);

    logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_preset;
    logic [NUM_TIMERS-1:0][SCL_W-1:0] scl_preset;
    logic [NUM_TIMERS-1:0][CNT_W-1:0] cnt_value;
    logic [NUM_TIMERS-1:0][SCL_W-1:0] scl_value;
    logic [NUM_TIMERS-1:0]            reload_mode;
    logic [NUM_TIMERS-1:0]            count_en;
    logic [NUM_TIMERS-1:0]            ld_cnt;
    logic [NUM_TIMERS-1:0]            ld_scl;
    logic [NUM_TIMERS-1:0]            tick;
    logic [NUM_TIMERS-1:0]            expire;

    dpt_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SCL_W  (SCL_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .cnt_preset  (cnt_preset),
        .scl_preset  (scl_preset),
        .reload_mode (reload_mode),
        .count_en    (count_en),
        .ld_cnt      (ld_cnt),
        .ld_scl      (ld_scl)
    );

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        dpt_scaler #(.SCL_W(SCL_W)) u_scaler (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (count_en[i]),
            .load   (ld_scl[i]),
            .preset (scl_preset[i]),
            .value  (scl_value[i]),
            .tick   (tick[i])
        );

        dpt_counter #(.CNT_W(CNT_W)) u_counter (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick        (tick[i]),
            .load        (ld_cnt[i]),
            .reload_mode (reload_mode[i]),
            .preset      (cnt_preset[i]),
            .value       (cnt_value[i]),
            .expire      (expire[i])
        );
    end

    assign gp_expire = expire[0];
    assign rt_expire = expire[1];

    // Read multiplexer; the control word and unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        for (int t = 0; t < NUM_TIMERS; t++) begin
            if (addr == ADDR_W'(cnt_preset_addr(t))) rdata = DATA_W'(cnt_preset[t]);
            if (addr == ADDR_W'(scl_preset_addr(t))) rdata = DATA_W'(scl_preset[t]);
            if (addr == ADDR_W'(cnt_value_addr(t)))  rdata = DATA_W'(cnt_value[t]);
            if (addr == ADDR_W'(scl_value_addr(t)))  rdata = DATA_W'(scl_value[t]);
        end
    end

    // R10
    gp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en[0] && !ld_cnt[0]) |=> (!expire[0] && $stable(cnt_value[0])));

endmodule

// File: tb/sim_dual_prescaled_timer.sv
// sim_dual_prescaled_timer: behavioural reference model compared against
// the design on every clock (expiry outputs and read data).
module sim_dual_prescaled_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        gp_expire;
    logic        rt_expire;

    int checks = 0;
    int failures = 0;
    bit chk_on = 0;
    bit done = 0;
    string tag = "R1";
    int rd_ptr = 0;

    // reference state
    int m_cp [2];
    int m_sp [2];
    int m_cnt[2];
    int m_scl[2];
    bit m_rl [2];
    bit m_en [2];
    bit m_exp[2];

    always #10 clk = ~clk;   // 50 MHz

    dual_prescaled_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .gp_expire (gp_expire),
        .rt_expire (rt_expire)
    );

    function automatic int model_read(input int a);
        case (a)
            0: return m_cp[0];
            1: return m_sp[0];
            2: return m_cp[1];
            3: return m_sp[1];
            5: return m_cnt[0];
            6: return m_scl[0];
            7: return m_cnt[1];
            8: return m_scl[1];
            default: return 0;
        endcase
    endfunction

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 2; t++) begin
                m_cp[t] = 0; m_sp[t] = 0; m_cnt[t] = 0; m_scl[t] = 0;
                m_rl[t] = 0; m_en[t] = 0; m_exp[t] = 0;
            end
        end else begin
            for (int t = 0; t < 2; t++) begin
                bit ctrl, ldc, lds, tk;
                int b;
                b    = t * 8;
                ctrl = wr_en && addr == 4;
                ldc  = ctrl && wdata[b + 1];
                lds  = ctrl && wdata[b + 3];
                tk   = m_en[t] && m_scl[t] == 0 && !lds;
                m_exp[t] = !ldc && tk && m_cnt[t] == 1;
                if (ldc) m_cnt[t] = m_cp[t];
                else if (tk && m_cnt[t] != 0)
                    m_cnt[t] = (m_cnt[t] == 1) ? (m_rl[t] ? m_cp[t] : 0) : m_cnt[t] - 1;
                if (lds) m_scl[t] = m_sp[t];
                else if (m_en[t]) m_scl[t] = (m_scl[t] == 0) ? m_sp[t] : m_scl[t] - 1;
                if (ctrl) begin
                    m_rl[t] = wdata[b];
                    m_en[t] = wdata[b + 2];
                end
                if (wr_en && addr == 2 * t)     m_cp[t] = int'(wdata[15:0]);
                if (wr_en && addr == 2 * t + 1) m_sp[t] = int'(wdata[15:0]);
            end
        end
    end

    task automatic check(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Compare away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check("gp_expire", int'(gp_expire), int'(m_exp[0]));
            check("rt_expire", int'(rt_expire), int'(m_exp[1]));
            check($sformatf("rdata@%0d", addr), int'(rdata), model_read(int'(addr)));
        end
    end

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #2;
            wr_en = 1'b0;
            addr  = 4'(rd_ptr % 9);
            rd_ptr++;
        end
    endtask

    task automatic wr(input int a, input int d);
        @(posedge clk); #2;
        wr_en = 1'b1;
        addr  = 4'(a);
        wdata = 32'(d);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state, all addresses read zero
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        chk_on = 1;
        tag = "R1";
        idle(10);

        // R9: preset readback, control word reads zero
        tag = "R9";
        wr(0, 5); wr(1, 2); wr(2, 3); wr(3, 0);
        wr(4, 32'h0000_0000);
        idle(18);

        // R3: timer 0 reloading, prescaler period 3, counter 5
        tag = "R3";
        wr(4, 32'h0000_000F);
        idle(60);

        // R4 / R8: start timer 1 in stop mode, restate timer 0 mode bits
        tag = "R8";
        wr(4, 32'h0000_0E05);
        idle(5);
        tag = "R4";
        idle(20);

        // R7: disable both, values must hold
        tag = "R7";
        wr(4, 32'h0000_0000);
        idle(12);
        wr(4, 32'h0000_0005);
        idle(10);

        // R5: counter loads at sweeping offsets to hit load-vs-tick collision
        tag = "R5";
        for (int k = 0; k < 18; k++) begin
            wr(4, 32'h0000_0007);
            idle(k);
        end
        // R5: zero command bits have no effect
        wr(4, 32'h0000_0005);
        idle(20);

        // R6: prescaler loads at sweeping offsets
        tag = "R6";
        wr(1, 6);
        for (int k = 0; k < 10; k++) begin
            wr(4, 32'h0000_000D);
            idle(k);
        end
        idle(30);

        // R10: both timers reloading together
        tag = "R10";
        wr(4, 32'h0000_0F0F);
        idle(60);

        // R2: prescaler preset 0 and counter preset 1 expire every clock
        tag = "R2";
        wr(0, 1); wr(1, 0);
        wr(4, 32'h0000_0F0F);
        idle(15);

        finish_run();
    end

endmodule